// File: doc/BRIEF.md
# Alert Response Responder

This block is the device-side half of a shared-bus alert scheme on a two-wire serial bus. When local logic raises an event, the block pulls a separate active-low alert wire low, asking the host for attention. The host answers by performing a one-byte read from a reserved alert response address. Every device that is still alerting replies with its own 7-bit address. The replies are resolved bit by bit through the wired-AND data line, so the lowest address wins.

The block watches the already-synchronized clock and data lines and detects start and stop conditions. It acknowledges the alert response read only while its own alert is pending. It then shifts its address out MSB first. When the line shows a 0 in a bit where it released the line for a 1, it drops out for the rest of the transfer. Only a device that sends its whole address undisturbed, and then sees a stop, releases its alert and pulses a serviced strobe. A device that loses keeps alerting and competes again on a later read. All outputs are open-drain enables: a 1 means "pull the wire low".

Top module: `alrt_resp`

## Requirements
- R1: A high `event_req` sampled at a clock edge sets the pending alert, so `alert_oe` is 1 from the next cycle until the alert is serviced.
- R2: While `rst` is high, `sda_oe`, `alert_oe` and `serviced` are 0 after the next clock edge.
- R3: After a start, the block acknowledges by driving `sda_oe` high during the ninth clock only if the received byte is 0x19 (address 0x0C in bits 7..1, read bit 1 in bit 0) and the alert is pending. It drives from the falling SCL edge after the eighth rising edge until the falling edge after the ninth. Any other byte, or a byte received while not pending, leaves `sda_oe` at 0 until the next start.
- R4: After acknowledging, the block sends the byte {dev_addr, 0} MSB first, changing the drive at each SCL falling edge. It sets `sda_oe` to 1 for a 0 bit and to 0 for a 1 bit. It releases the line at the falling edge after the eighth data bit and ignores the host's acknowledge bit.
- R5: If a rising SCL edge samples the data line at 0 during a bit where the block released it, the block stops driving for the rest of the transfer, keeps `alert_oe` at 1, and may win a later read.
- R6: A stop that follows a reply sent in full produces a one-cycle `serviced` pulse in the cycle after the stop is sampled. `alert_oe` falls in the cycle after the pulse.
- R7: `sda_oe` only changes while SCL is low.
- R8: A start at any point restarts address reception. A repeated start after a winning reply cancels the win, so no `serviced` pulse is produced. A stop returns the block to idle.
- R9: An `event_req` sampled in the same cycle as `serviced` keeps the alert pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| event_req | input | 1 | Local request to raise an alert |
| dev_addr | input | ADDR_W | This device's bus address, returned in the reply |
| sda_oe | output | 1 | Pull data line low when 1 |
| alert_oe | output | 1 | Pull alert line low when 1 |
| serviced | output | 1 | One-cycle strobe when the alert has been taken |

## Verification
The hardest situation to reach is a lost arbitration in the middle of the reply. It needs a second replying device whose address has a 0 where this block's address has a 1. The bench models that competitor on the wired-AND data line: it pulls the line low for its own 0 bits until it loses. The bench then follows the loss with a fresh read that the block must win. Repeated starts are also driven, both in the middle of an address byte and right after a winning reply. These show that the win is cancelled and that reception restarts cleanly.

// File: rtl/alrt_pkg.sv
package alrt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // bus free or not yet addressed
    ST_ADDR,   // shifting in the address byte
    ST_ACKW,   // matched, wait for falling edge to start ACK
    ST_ACKH,   // holding ACK low
    ST_SEND,   // shifting out own address
    ST_MACK,   // last reply bit on the wire, release at next fall
    ST_WON,    // reply complete, waiting for stop
    ST_SKIP    // not addressed or lost, wait for start/stop
  } rsp_state_e;
endpackage

// File: rtl/alrt_linecond.sv
module alrt_linecond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise = scl_i & ~scl_q;
    scl_fall = ~scl_i & scl_q;
    start_c  = scl_i & scl_q & sda_q & ~sda_i;
    stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/alrt_pending.sv
module alrt_pending (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst) pend_o <= 1'b0;
    else     pend_o <= set_i | (pend_o & ~clr_i);
  end
endmodule

// File: rtl/alrt_engine.sv
module alrt_engine
  import alrt_pkg::*;
#(
  parameter int               ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_i,
  input  logic              pend_i,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_oe_o,
  output logic              serviced_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_RD = {ARA_ADDR, 1'b1};

  rsp_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] reply;
  logic [CNT_W-1:0]  tx_idx;
  logic              match;

  always_comb begin
    rx_byte = {rx_sh, sda_i};
    reply   = {dev_addr, 1'b0};
    tx_idx  = LAST - bit_cnt;
    match   = (rx_byte == ARA_RD) && pend_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      sda_oe_o   <= 1'b0;
      serviced_o <= 1'b0;
    end else begin
      serviced_o <= 1'b0;
      if (stop_c) begin
        serviced_o <= (state == ST_WON);
        state      <= ST_IDLE;
        bit_cnt    <= '0;
        sda_oe_o   <= 1'b0;
      end else if (start_c) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            rx_sh <= rx_byte[BYTE_W-2:0];
            if (bit_cnt == LAST) begin
              bit_cnt <= '0;
              state   <= match ? ST_ACKW : ST_SKIP;
            end else begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end
          ST_ACKW: if (scl_fall) begin
            sda_oe_o <= 1'b1;
            state    <= ST_ACKH;
          end
          ST_ACKH: if (scl_fall) begin
            sda_oe_o <= ~reply[BYTE_W-1];
            bit_cnt  <= '0;
            state    <= ST_SEND;
          end
          ST_SEND: begin
            if (scl_rise) begin
              if (!sda_oe_o && !sda_i) begin
                state <= ST_SKIP;
              end else if (bit_cnt == LAST) begin
                state <= ST_MACK;
              end else begin
                bit_cnt <= bit_cnt + CNT_W'(1);
              end
            end else if (scl_fall) begin
              sda_oe_o <= ~reply[tx_idx];
            end
          end
          ST_MACK: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            state    <= ST_WON;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/alrt_resp.sv
module alrt_resp #(
  parameter int               ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              event_req,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_oe,
  output logic              alert_oe,
  output logic              serviced
);
  logic scl_rise, scl_fall, start_c, stop_c;

  alrt_linecond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  alrt_pending u_pend (
    .clk(clk), .rst(rst), .set_i(event_req), .clr_i(serviced),
    .pend_o(alert_oe)
  );

  alrt_engine #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_eng (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c),
    .sda_i(sda_i), .pend_i(alert_oe), .dev_addr(dev_addr),
    .sda_oe_o(sda_oe), .serviced_o(serviced)
  );
endmodule

// File: rtl/alrt_resp_chk.sv
module alrt_resp_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_i,
  input logic event_req,
  input logic sda_oe,
  input logic alert_oe,
  input logic serviced
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sda_oe && !alert_oe && !serviced)); // R2
  AST_EVENT_RAISES: assert property (@(posedge clk) disable iff (rst)
    event_req |=> alert_oe); // R1
  AST_DRIVE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> alert_oe); // R3
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i)); // R7
  AST_SERV_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    serviced |-> ($past(scl_i) && $past(sda_i) && !$past(sda_i, 2))); // R6
  AST_SERV_PULSE: assert property (@(posedge clk) disable iff (rst)
    serviced |=> !serviced); // R6
  AST_SERV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (serviced && !event_req) |=> !alert_oe); // R6
  AST_SERV_EVENT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (serviced && event_req) |=> alert_oe); // R9
endmodule

bind alrt_resp alrt_resp_chk u_chk (.*);

// File: tb/alrt_resp_bench.sv
`timescale 1ns/1ps
module alrt_resp_bench;
  localparam int H = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, oth_low = 1'b0, ev = 1'b0;
  logic [6:0] dev = 7'h2A;
  logic sda_line, sda_oe, alert_oe, serviced;
  int checks = 0, fails = 0;
  logic exp_oe = 1'b0, exp_al = 1'b0, exp_sv = 1'b0;
  logic mon_en = 1'b0, prev_oe = 1'b0;
  string tag = "R2";
  logic won;

  assign sda_line = sda_m & ~sda_oe & ~oth_low;
  always #4 clk = ~clk;

  alrt_resp u_alrt_resp (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .event_req(ev), .dev_addr(dev),
    .sda_oe(sda_oe), .alert_oe(alert_oe), .serviced(serviced)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      checks += 4;
      if (sda_oe !== exp_oe) begin
        fails++; $display("FAIL %s sda_oe got %0b exp %0b at %0t", tag, sda_oe, exp_oe, $time);
      end
      if (alert_oe !== exp_al) begin
        fails++; $display("FAIL %s alert_oe got %0b exp %0b at %0t", tag, alert_oe, exp_al, $time);
      end
      if (serviced !== exp_sv) begin
        fails++; $display("FAIL %s serviced got %0b exp %0b at %0t", tag, serviced, exp_sv, $time);
      end
      if (sda_oe !== prev_oe && scl_m) begin  // R7 drive change only with SCL low
        fails++; $display("FAIL R7 sda_oe changed with SCL high got %0b exp %0b", sda_oe, prev_oe);
      end
    end
    prev_oe = sda_oe;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_bit(input logic m, input logic o, input logic nx);
    wait_cyc(1); sda_m = m; oth_low = o;
    wait_cyc(H); scl_m = 1'b1;
    wait_cyc(H); scl_m = 1'b0;
    @(posedge clk); #1; exp_oe = nx;
  endtask

  task automatic start_cond();
    wait_cyc(1); sda_m = 1'b1; oth_low = 1'b0;
    wait_cyc(H); scl_m = 1'b1;
    wait_cyc(H); sda_m = 1'b0;
    wait_cyc(H); scl_m = 1'b0;
    @(posedge clk); #1; exp_oe = 1'b0;
  endtask

  task automatic stop_cond(input logic w, input logic evs);
    wait_cyc(1); sda_m = 1'b0; oth_low = 1'b0;
    wait_cyc(H); scl_m = 1'b1;
    wait_cyc(H); sda_m = 1'b1;
    @(posedge clk); #1; exp_sv = w; #1 ev = evs;
    @(posedge clk); #1; exp_sv = 1'b0; if (w) exp_al = evs; #1 ev = 1'b0;
    wait_cyc(H);
  endtask

  task automatic raise_event();
    wait_cyc(1); ev = 1'b1;
    @(posedge clk); #1; exp_al = 1'b1; #1 ev = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, input logic ack);
    for (int i = 0; i < 8; i++) send_bit(b[7-i], 1'b0, (i == 7) ? ack : 1'b0);
  endtask

  // alert response read with an optional competing replier on the line
  task automatic ara_read(input logic [6:0] comp, input logic has_comp, output logic w);
    logic acked, dut_lost, comp_lost, ob, cb, cdrv, ddrv, line;
    logic [7:0] reply, cbyte;
    acked = exp_al; reply = {dev, 1'b0}; cbyte = {comp, 1'b0};
    dut_lost = 1'b0; comp_lost = 1'b0;
    start_cond();
    write_byte(8'h19, acked);
    send_bit(1'b1, 1'b0, acked & ~reply[7]);
    for (int i = 0; i < 8; i++) begin
      ob = reply[7-i];
      cb = has_comp ? cbyte[7-i] : 1'b1;
      cdrv = has_comp && !comp_lost && !cb;
      ddrv = acked && !dut_lost && !ob;
      line = !(cdrv || ddrv);
      if (acked && !dut_lost && ob && !line) dut_lost = 1'b1;
      if (has_comp && !comp_lost && cb && !line) comp_lost = 1'b1;
      send_bit(1'b1, cdrv, (i < 7) ? (acked && !dut_lost && !reply[6-i]) : 1'b0);
    end
    send_bit(1'b1, 1'b0, 1'b0);  // host NACK, ignored
    w = acked && !dut_lost;
  endtask

  initial begin
    wait_cyc(5);
    tag = "R2";
    checks += 3;
    if (sda_oe !== 1'b0 || alert_oe !== 1'b0 || serviced !== 1'b0) begin
      fails++; $display("FAIL R2 reset outputs got %0b%0b%0b exp 000", sda_oe, alert_oe, serviced);
    end
    rst = 1'b0; mon_en = 1'b1;
    wait_cyc(4);

    tag = "R3"; // read to 0x0C with nothing pending: no ACK
    ara_read(7'h00, 1'b0, won);
    stop_cond(won, 1'b0);

    tag = "R1";
    raise_event();
    wait_cyc(10);

    tag = "R3"; // write to 0x0C (byte 0x18) and read of 0x33: ignored
    start_cond(); write_byte(8'h18, 1'b0); send_bit(1'b1, 1'b0, 1'b0);
    write_byte(8'hA5, 1'b0); send_bit(1'b1, 1'b0, 1'b0); stop_cond(1'b0, 1'b0);
    start_cond(); write_byte(8'h67, 1'b0); send_bit(1'b1, 1'b0, 1'b0);
    write_byte(8'hFF, 1'b0); send_bit(1'b1, 1'b0, 1'b0); stop_cond(1'b0, 1'b0);

    tag = "R5"; // lower competitor 0x21 beats 0x2A
    ara_read(7'h21, 1'b1, won);
    stop_cond(won, 1'b0);

    tag = "R4"; // higher competitor 0x55 loses, retry wins
    ara_read(7'h55, 1'b1, won);
    tag = "R6";
    stop_cond(won, 1'b0);

    tag = "R8"; // start in mid address, then win, then repeated start
    raise_event();
    start_cond();
    for (int i = 0; i < 4; i++) send_bit((i == 3), 1'b0, 1'b0);
    ara_read(7'h00, 1'b0, won);
    start_cond(); write_byte(8'hA0, 1'b0); send_bit(1'b1, 1'b0, 1'b0);
    stop_cond(1'b0, 1'b0);

    tag = "R9"; // new event in the serviced cycle keeps alert
    ara_read(7'h00, 1'b0, won);
    stop_cond(won, 1'b1);

    tag = "R4"; // different address pattern
    dev = 7'h03;
    ara_read(7'h7F, 1'b1, won);
    tag = "R6";
    stop_cond(won, 1'b0);

    tag = "R3"; // after service, read is ignored again
    ara_read(7'h00, 1'b0, won);
    stop_cond(won, 1'b0);

    wait_cyc(10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired, got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule